// File: doc/BRIEF.md
# Mailbox Command Request Engine

This block is a host-side sequencer that carries one request to a coprocessor over a shared message area and two mailbox registers, then collects and judges the answer. A request starts from a one-cycle `start` pulse together with a command index. The engine expands the index into a built-in five-word message, writes that message over a simple single-outstanding register bus, and writes the outbound mailbox to tell the coprocessor that work is waiting. It then reads the inbound mailbox at a fixed spacing until the value is nonzero or a poll budget runs out.

On an answer the engine reads the five message words back and checks the additive checksum. In every case it ends by writing zero to the inbound mailbox. It then pulses `done` with a small error index. The five reply words stay on `reply_words` until the next request begins. The coprocessor and bus arbitration lie outside the block.

Top module: `mbx_cmd_engine`

## Requirements
- R1: An accepted request writes five words, in order, to addresses 0x100, 0x104, 0x108, 0x10C and 0x110. The words are header=1, opcode, argument count=1, argument, and check word = the sum of the other four. The opcode/argument pair is 1/1 for index 0, 2/1 for index 1 and 2/2 for index 2.
- R2: Directly after the fifth message write, the engine writes the value 1 to the outbound mailbox at address 0x10.
- R3: The engine then reads the inbound mailbox at 0x14 and stops at the first nonzero value. Two successive polls are at least POLL_GAP+1 cycles apart.
- R4: After POLL_LIMIT polls that all read zero, the engine reads no message words. It writes 0 to 0x14 and reports error index 5 (timeout), with `reply_words` all zero.
- R5: On a nonzero poll the engine reads the five words at 0x100..0x110 in order and then writes 0 to 0x14. `reply_words[k]` then holds word k.
- R6: If the fifth reply word differs from the 32-bit wrapping sum of the first four, the error index is 3 (bad checksum), whatever the mailbox value was.
- R7: With a good checksum, the error index is the 1-based position of the lowest set bit of the mailbox value with bit 31 cleared. Bit 0 gives 1 and bit 3 gives 4, and a value of 1 (success) gives 0.
- R8: A command index of 3 or more produces no bus traffic. `done` follows in the cycle after `start` is sampled, with error index 2.
- R9: Once `bus_req` is raised, it stays high with the address, direction and write data unchanged until `bus_ready` is seen.
- R10: `done` is a one-cycle pulse. `busy` is high from the cycle after acceptance until `done`, and a `start` seen while busy is ignored.
- R11: After reset, `bus_req`, `busy`, `done` and `err_idx` are 0 and `reply_words` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| cmd_idx | input | IDX_W | Command template index |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_idx | output | 5 | Error index, 0 on success |
| reply_words | output | 5x32 | Reply message words, word k at [k] |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Transfer accepted; read data valid |
| bus_rdata | input | 32 | Read data |

## Verification
Most internal faults become visible on the bus within a few transfers. A wrong word counter moves an address, a wrong template changes write data, and a stuck state shows up as a missing mailbox clear or a missing `done` before the watchdog. Faults in the poll counter change how many zero reads occur before the timeout, so the bench counts polls and checks their spacing. Faults in the checksum or bit-index logic appear only in `err_idx` at the `done` pulse. They are exercised with replies that have good and bad check words and mailbox values with different lowest bits.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_WORDS = 5;
  localparam int NUM_CMDS  = 3;
  localparam int ERR_W     = 5;

  localparam logic [31:0] ST_FAIL_FLAG = 32'h8000_0000;
  localparam logic [31:0] ST_INVAL     = ST_FAIL_FLAG | 32'h2;
  localparam logic [31:0] ST_CHKSUM    = ST_FAIL_FLAG | 32'h4;
  localparam logic [31:0] ST_TIMEOUT   = ST_FAIL_FLAG | 32'h10;

  localparam logic [11:0] OFS_MSG  = 12'h100;
  localparam logic [11:0] OFS_OUTB = 12'h010;
  localparam logic [11:0] OFS_INB  = 12'h014;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_RING, ST_POLL, ST_GAP, ST_FETCH, ST_CLEAR
  } eng_state_e;

  typedef logic [NUM_WORDS-1:0][31:0] msg_t;

  // Template word k of command idx; last word is the sum of the others.
  function automatic logic [31:0] tmpl_word(input logic [1:0] idx, input logic [2:0] k);
    logic [31:0] opc, arg;
    opc = (idx == 2'd0) ? 32'd1 : 32'd2;
    arg = (idx == 2'd2) ? 32'd2 : 32'd1;
    case (k)
      3'd0:    return 32'd1;
      3'd1:    return opc;
      3'd2:    return 32'd1;
      3'd3:    return arg;
      default: return 32'd2 + opc + arg;
    endcase
  endfunction

  function automatic logic [31:0] head_sum(input msg_t m);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < NUM_WORDS - 1; i++) s = s + m[i];
    return s;
  endfunction

  // 1-based index of lowest set bit after removing the failure flag; 0 if none.
  function automatic logic [ERR_W-1:0] low_bit_pos(input logic [31:0] st);
    logic [31:0] v;
    logic [ERR_W-1:0] pos;
    v = st & ~ST_FAIL_FLAG;
    pos = '0;
    for (int i = 30; i >= 0; i--)
      if (v[i]) pos = ERR_W'(i + 1);
    return pos;
  endfunction
endpackage

// File: rtl/mbx_poll_pacer.sv
module mbx_poll_pacer #(
  parameter int POLL_GAP   = 16,
  parameter int POLL_LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic zero_poll,
  input  logic in_gap,
  output logic last_poll,
  output logic gap_over
);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam int GAP_W = $clog2(POLL_GAP + 1);

  logic [CNT_W-1:0] poll_cnt;
  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         poll_cnt <= '0;
    else if (arm)       poll_cnt <= '0;
    else if (zero_poll) poll_cnt <= poll_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !in_gap) gap_cnt <= '0;
    else                   gap_cnt <= gap_cnt + 1'b1;
  end

  assign last_poll = (poll_cnt == CNT_W'(POLL_LIMIT - 1));
  assign gap_over  = in_gap && (gap_cnt == GAP_W'(POLL_GAP - 1));

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    zero_poll |-> (poll_cnt < CNT_W'(POLL_LIMIT))); // R4
endmodule

// File: rtl/mbx_reply_eval.sv
module mbx_reply_eval
  import mbx_pkg::*;
(
  input  msg_t              reply,
  input  logic [31:0]       mbox_val,
  output logic              sum_ok,
  output logic [ERR_W-1:0]  err_idx
);
  logic [31:0] status;

  assign sum_ok  = (head_sum(reply) == reply[NUM_WORDS-1]);
  assign status  = sum_ok ? mbox_val : ST_CHKSUM;
  assign err_idx = (status == 32'd1) ? '0 : low_bit_pos(status);
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
  import mbx_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int IDX_W      = 2,
  parameter int POLL_GAP   = 16,
  parameter int POLL_LIMIT = 200000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [IDX_W-1:0]                  cmd_idx,
  output logic                              busy,
  output logic                              done,
  output logic [4:0]                        err_idx,
  output logic [4:0][31:0]                  reply_words,
  output logic                              bus_req,
  output logic                              bus_we,
  output logic [ADDR_W-1:0]                 bus_addr,
  output logic [31:0]                       bus_wdata,
  input  logic                              bus_ready,
  input  logic [31:0]                       bus_rdata
);
  localparam logic [ADDR_W-1:0] A_MSG  = ADDR_W'(OFS_MSG);
  localparam logic [ADDR_W-1:0] A_OUTB = ADDR_W'(OFS_OUTB);
  localparam logic [ADDR_W-1:0] A_INB  = ADDR_W'(OFS_INB);
  localparam logic [2:0]        LAST_K = 3'(NUM_WORDS - 1);
  localparam logic [ERR_W-1:0]  IDX_TIMEOUT = low_bit_pos(ST_TIMEOUT);
  localparam logic [ERR_W-1:0]  IDX_INVAL   = low_bit_pos(ST_INVAL);

  eng_state_e       state;
  logic [2:0]       word_k;
  logic [1:0]       cmd_q;
  logic [31:0]      mbox_q;
  logic             timed_out;
  msg_t             reply_q;

  logic             xfer, accept, reject, zero_poll, last_poll, gap_over;
  logic             sum_ok;
  logic [ERR_W-1:0] eval_idx;

  assign xfer      = bus_req && bus_ready;
  assign accept    = (state == ST_IDLE) && start && (cmd_idx < IDX_W'(NUM_CMDS));
  assign reject    = (state == ST_IDLE) && start && !(cmd_idx < IDX_W'(NUM_CMDS));
  assign zero_poll = (state == ST_POLL) && xfer && (bus_rdata == 32'd0);

  mbx_poll_pacer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_pacer (
    .clk(clk), .rst_n(rst_n), .arm(accept), .zero_poll(zero_poll),
    .in_gap(state == ST_GAP), .last_poll(last_poll), .gap_over(gap_over)
  );

  mbx_reply_eval u_eval (
    .reply(reply_q), .mbox_val(mbox_q), .sum_ok(sum_ok), .err_idx(eval_idx)
  );

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = A_INB;
    bus_wdata = 32'd0;
    unique case (state)
      ST_SEND: begin
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr  = A_MSG + ADDR_W'({word_k, 2'b00});
        bus_wdata = tmpl_word(cmd_q, word_k);
      end
      ST_RING:  begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_OUTB; bus_wdata = 32'd1; end
      ST_POLL:  begin bus_req = 1'b1; end
      ST_FETCH: begin bus_req = 1'b1; bus_addr = A_MSG + ADDR_W'({word_k, 2'b00}); end
      ST_CLEAR: begin bus_req = 1'b1; bus_we = 1'b1; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      word_k    <= '0;
      cmd_q     <= '0;
      mbox_q    <= '0;
      timed_out <= 1'b0;
      reply_q   <= '0;
      done      <= 1'b0;
      err_idx   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cmd_q     <= cmd_idx[1:0];
            word_k    <= '0;
            mbox_q    <= '0;
            timed_out <= 1'b0;
            reply_q   <= '0;
            state     <= ST_SEND;
          end else if (reject) begin
            done    <= 1'b1;
            err_idx <= IDX_INVAL;
          end
        end
        ST_SEND: if (xfer) begin
          if (word_k == LAST_K) state <= ST_RING;
          else word_k <= word_k + 1'b1;
        end
        ST_RING: if (xfer) state <= ST_POLL;
        ST_POLL: if (xfer) begin
          if (bus_rdata != 32'd0) begin
            mbox_q <= bus_rdata;
            word_k <= '0;
            state  <= ST_FETCH;
          end else if (last_poll) begin
            timed_out <= 1'b1;
            state     <= ST_CLEAR;
          end else begin
            state <= ST_GAP;
          end
        end
        ST_GAP: if (gap_over) state <= ST_POLL;
        ST_FETCH: if (xfer) begin
          reply_q[word_k] <= bus_rdata;
          if (word_k == LAST_K) state <= ST_CLEAR;
          else word_k <= word_k + 1'b1;
        end
        ST_CLEAR: if (xfer) begin
          done    <= 1'b1;
          err_idx <= timed_out ? IDX_TIMEOUT : eval_idx;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign reply_words = reply_q;

  AST_RING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == A_OUTB) |-> (bus_wdata == 32'd1)); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == A_INB) |-> (bus_wdata == 32'd0)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_wdata))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req); // R8
  AST_BAD_SUM_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLEAR && xfer && !timed_out && !sum_ok) |=> (err_idx == 5'd3)); // R6
endmodule

// File: tb/mbx_cmd_engine_bench.sv
module mbx_cmd_engine_bench;
  localparam int GAP = 3;
  localparam int LIM = 6;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] cmd_idx = 0;
  logic busy, done, bus_req, bus_we;
  logic [4:0] err_idx;
  logic [4:0][31:0] reply_words;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = 0;
  logic bus_ready = 0;

  always #4 clk = ~clk;

  mbx_cmd_engine #(.ADDR_W(12), .IDX_W(2), .POLL_GAP(GAP), .POLL_LIMIT(LIM)) u_mbx_cmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .busy(busy), .done(done),
    .err_idx(err_idx), .reply_words(reply_words), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata));

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // Coprocessor model and transaction log
  logic [31:0] cfg_resp;
  logic [4:0][31:0] cfg_reply;
  int cfg_delay, left, armed, wcnt, served, zero_polls, gap_bad, last_poll_cyc, done_cnt;
  int n_log;
  logic [11:0] log_a [64];
  logic        log_w [64];
  logic [31:0] log_d [64];

  task automatic put_log(input logic [11:0] a, input logic w, input logic [31:0] d);
    if (n_log < 64) begin log_a[n_log] = a; log_w[n_log] = w; log_d[n_log] = d; end
    n_log++;
  endtask

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (!rst_n) begin
      bus_ready = 0; wcnt = 0;
    end else if (bus_ready) begin
      bus_ready = 0;
    end else if (bus_req) begin
      if (wcnt < served % 3) wcnt++;
      else begin
        wcnt = 0; served++; bus_ready = 1;
        if (bus_we) begin
          if (bus_addr == 12'h010 && bus_wdata == 1) begin armed = 1; left = cfg_delay; end
          put_log(bus_addr, 1, bus_wdata);
        end else if (bus_addr == 12'h014) begin
          if (last_poll_cyc >= 0 && cyc - last_poll_cyc < GAP + 1) gap_bad++;
          last_poll_cyc = cyc;
          if (armed != 0 && left == 0) begin bus_rdata = cfg_resp; put_log(bus_addr, 0, cfg_resp); end
          else begin bus_rdata = 0; zero_polls++; if (left > 0) left--; end
        end else begin
          bus_rdata = cfg_reply[(bus_addr - 12'h100) >> 2];
          put_log(bus_addr, 0, bus_rdata);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [31:0] exp_word(input int idx, input int k);
    int op, ag;
    op = (idx == 0) ? 1 : 2; ag = (idx == 2) ? 2 : 1;
    case (k) 0: return 1; 1: return op; 2: return 1; 3: return ag; default: return 2 + op + ag; endcase
  endfunction

  function automatic int exp_err(input logic [4:0][31:0] r, input logic [31:0] resp);
    logic [31:0] st;
    st = (r[0] + r[1] + r[2] + r[3] == r[4]) ? resp : 32'h8000_0004;
    if (st == 1) return 0;
    st[31] = 0;
    for (int b = 0; b < 31; b++) if (st[b]) return b + 1;
    return 0;
  endfunction

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) check(0, "R10 watchdog", 0, 1);
  endtask

  task automatic pulse(input logic [1:0] idx);
    @(negedge clk); start = 1; cmd_idx = idx;
    @(negedge clk); start = 0;
  endtask

  task automatic setup(input int delay, input logic [31:0] resp, input logic [4:0][31:0] r);
    cfg_delay = delay; cfg_resp = resp; cfg_reply = r;
    armed = 0; left = 0; n_log = 0; zero_polls = 0; gap_bad = 0; last_poll_cyc = -1;
  endtask

  task automatic run_req(input logic [1:0] idx, input int delay, input logic [31:0] resp,
                         input logic [4:0][31:0] r, input string tag);
    int base;
    bit tmo;
    setup(delay, resp, r);
    tmo = (delay >= LIM);
    pulse(idx);
    check(busy == 1, {"R10 busy ", tag}, busy, 1);
    wait_done();
    for (int k = 0; k < 5; k++) begin
      check(log_w[k] == 1 && log_a[k] == 12'h100 + 4*k && log_d[k] == exp_word(idx, k),
            {"R1 write ", tag}, log_d[k], exp_word(idx, k));
    end
    check(log_w[5] == 1 && log_a[5] == 12'h010 && log_d[5] == 1, {"R2 ring ", tag}, log_d[5], 1);
    check(gap_bad == 0, {"R3 gap ", tag}, gap_bad, 0);
    if (tmo) begin
      check(zero_polls == LIM, {"R4 polls ", tag}, zero_polls, LIM);
      check(n_log == 7 && log_a[6] == 12'h014 && log_w[6] && log_d[6] == 0, {"R4 clear ", tag}, n_log, 7);
      check(err_idx == 5, {"R4 idx ", tag}, err_idx, 5);
      check(reply_words == '0, {"R4 words ", tag}, reply_words[0], 0);
    end else begin
      check(zero_polls == delay, {"R3 polls ", tag}, zero_polls, delay);
      check(n_log == 13 && log_a[6] == 12'h014 && !log_w[6], {"R3 stop ", tag}, n_log, 13);
      base = 7;
      for (int k = 0; k < 5; k++)
        check(!log_w[base+k] && log_a[base+k] == 12'h100 + 4*k, {"R5 read ", tag}, log_a[base+k], 12'h100 + 4*k);
      check(log_a[12] == 12'h014 && log_w[12] && log_d[12] == 0, {"R5 clear ", tag}, log_d[12], 0);
      check(reply_words == r, {"R5 words ", tag}, reply_words[4], r[4]);
      check(err_idx == exp_err(r, resp), {"R6/R7 idx ", tag}, err_idx, exp_err(r, resp));
    end
    @(negedge clk);
    check(done == 0 && busy == 0, {"R10 pulse ", tag}, done, 0);
  endtask

  function automatic logic [4:0][31:0] good(input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] c, input logic [31:0] d);
    logic [4:0][31:0] m;
    m[0] = a; m[1] = b; m[2] = c; m[3] = d; m[4] = a + b + c + d;
    return m;
  endfunction

  task automatic t_reset();
    check(bus_req == 0 && busy == 0 && done == 0 && err_idx == 0, "R11 ctrl", {bus_req, busy, done}, 0);
    check(reply_words == '0, "R11 words", reply_words[0], 0);
  endtask

  task automatic t_reject();
    int d0;
    setup(0, 1, '0);
    d0 = done_cnt;
    @(negedge clk); start = 1; cmd_idx = 3;
    @(negedge clk); start = 0;
    check(done == 1 && err_idx == 2, "R8 idx", err_idx, 2);
    @(negedge clk);
    check(n_log == 0 && zero_polls == 0 && done_cnt == d0 + 1, "R8 no traffic", n_log, 0);
  endtask

  task automatic t_busy_start();
    int d0;
    setup(1, 1, good(2, 2, 1, 9));
    d0 = done_cnt;
    pulse(2'd1);
    repeat (3) @(negedge clk);
    start = 1; cmd_idx = 0; @(negedge clk); start = 0;
    wait_done();
    check(err_idx == 0 && log_d[1] == 2, "R10 ignored start", log_d[1], 2);
    repeat (10) @(negedge clk);
    check(done_cnt == d0 + 1 && busy == 0, "R10 one done", done_cnt - d0, 1);
  endtask

  initial begin
    logic [4:0][31:0] bad;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    run_req(2'd0, 0, 32'h1, good(2, 1, 1, 7), "ok0");
    run_req(2'd1, 2, 32'h1, good(2, 2, 1, 32'hFFFF_FFF0), "ok1wrap");
    run_req(2'd2, 1, 32'h8000_0008, good(2, 2, 1, 3), "malformed");
    bad = good(2, 1, 1, 5); bad[4] = bad[4] + 1;
    run_req(2'd0, 0, 32'h1, bad, "badsum");
    run_req(2'd1, 0, 32'h8000_0001, bad, "badsum_hdr");
    run_req(2'd2, 0, 32'h20, good(1, 1, 1, 1), "bit5");
    run_req(2'd0, 0, 32'h8000_0003, good(4, 4, 4, 4), "twobits");
    run_req(2'd1, LIM + 5, 32'h1, good(2, 2, 1, 1), "timeout");
    t_reject();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule